// File: doc/BRIEF.md
# Dual-Memory FIR Tap Sequencer

This controller drives the computation of one output of an N-tap FIR filter, y[n] = sum over k of b[k]·x[n-k]. The coefficients b[k] are held in one data memory and the delayed input samples in a second, separate memory. Each memory has its own read port and its own address generator, so a coefficient and a sample are fetched together in one cycle. The multiply-accumulate unit itself sits outside the block. It takes its two operands straight from the two memory read ports and obeys the clear and fire strobes produced here.

After an accepted start, the block asserts the clear strobe with the first fetch. It then reads N coefficient/sample pairs in N consecutive cycles. Each pair is multiplied in the cycle after its fetch, while the next pair is being read, so no cycle is idle. The coefficient pointer restarts at the coefficient buffer base on every start. The sample pointer starts at the newest sample and walks backwards, wrapping modulo N. New samples enter through a write port that stores each one at a circular write pointer. That pointer advances modulo N, so the sample memory behaves as a circular delay line.

Top module: `fir_seq_ctrl`

## Requirements
- R1: After reset, busy, done, mac_fire, acc_clear, coef_re and samp_re are 0, and samp_waddr is 0, so the first sample written lands in slot 0.
- R2: When start is accepted at a clock edge, coef_re and samp_re are 1 for exactly the next TAPS cycles. acc_clear is 1 only in the first of those cycles.
- R3: In fetch cycle k (k = 0 for the first fetch), coef_addr equals COEF_BASE + k. This sequence restarts at COEF_BASE for every accepted start.
- R4: In fetch cycle k, samp_raddr equals (s0 - k) mod TAPS, where s0 is the slot of the newest sample stored when start was accepted. Address 0 is followed by TAPS-1.
- R5: mac_fire is 1 exactly in the cycle after each fetch cycle. With memories of one-cycle read latency, the operands presented in the k-th fire cycle are b[k] and x[n-k]. A slot never written reads as 0 in the bench memory.
- R6: done is a single-cycle pulse in the (TAPS+2)-th cycle after the edge that accepted start. busy is 1 from the first fetch cycle through the last fire cycle.
- R7: start is ignored while busy is 1. The address sequences and the done timing are unchanged, and no further fetch follows done. start is accepted again in the done cycle.
- R8: smp_valid makes samp_we 1 in the same cycle, with samp_wdata = smp_data and samp_waddr = the current write slot. The write slot then advances by one modulo TAPS.
- R9: A sample written in the same cycle as an accepted start is the newest sample, x[n], of that computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one output computation |
| smp_valid | input | 1 | New input sample present this cycle |
| smp_data | input | DW | New input sample value |
| coef_re | output | 1 | Coefficient memory read enable |
| coef_addr | output | CAW | Coefficient memory read address |
| samp_re | output | 1 | Sample memory read enable |
| samp_raddr | output | SAW | Sample memory read address |
| samp_we | output | 1 | Sample memory write enable |
| samp_waddr | output | SAW | Sample memory write address (circular write slot) |
| samp_wdata | output | DW | Sample memory write data |
| acc_clear | output | 1 | Clear the accumulator |
| mac_fire | output | 1 | Accumulate the product of the memory read data |
| done | output | 1 | Output sample complete (one-cycle pulse) |
| busy | output | 1 | Computation in progress |

## Verification
A new-sample write and the loading of the sample read pointer by an accepted start can fall in the same cycle. The bench provokes this by raising smp_valid together with start. It then judges the result through its memory model and scoreboard: the first fire cycle must present the just-written value as x[n], and the walk must start at that value's slot. A second overlap is a start raised in the middle of a run while the fetch and fire strobes are active. Here the address walk, the done timing and the quiet cycles after done must all be unchanged.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

  // One step around a ring of len slots, upward or downward.
  function automatic int unsigned ring_next(int unsigned p, int unsigned len, bit down);
    if (down) return (p == 0) ? len - 1 : p - 1;
    return (p + 1 >= len) ? 0 : p + 1;
  endfunction

  // Slot holding the newest sample: the slot being written now, else the one before the write slot.
  function automatic int unsigned newest_slot(int unsigned wr_slot, int unsigned len, bit wr_now);
    return wr_now ? wr_slot : ring_next(wr_slot, len, 1'b1);
  endfunction

endpackage

// File: rtl/fir_ring_agu.sv
module fir_ring_agu #(
  parameter int unsigned LEN  = 8,
  parameter int unsigned AW   = 3,
  parameter bit          DOWN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  import fir_seq_pkg::*;

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_step;

  assign ptr_step = AW'(ring_next(32'(ptr_q), LEN, DOWN));

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (step) ptr_q <= ptr_step;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/fir_tap_ctrl.sv
module fir_tap_ctrl #(
  parameter int unsigned TAPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic fetch,
  output logic first_fetch,
  output logic last_fetch,
  output logic fire,
  output logic done,
  output logic busy
);
  localparam int unsigned CW = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TAPS - 1);

  logic [CW-1:0] cnt_q;
  logic fetch_q, fire_q, last_q, done_q;

  assign accept      = start & ~fetch_q & ~fire_q;
  assign first_fetch = fetch_q && (cnt_q == '0);
  assign last_fetch  = fetch_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fetch_q <= 1'b0;
      fire_q  <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      fire_q <= fetch_q;
      last_q <= last_fetch;
      done_q <= fire_q & last_q;
      if (accept) begin
        fetch_q <= 1'b1;
        cnt_q   <= '0;
      end else if (fetch_q) begin
        if (last_fetch) fetch_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fetch = fetch_q;
  assign fire  = fire_q;
  assign done  = done_q;
  assign busy  = fetch_q | fire_q;
endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl #(
  parameter int unsigned TAPS      = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned CAW       = 6,
  parameter int unsigned COEF_BASE = 0,
  localparam int unsigned SAW      = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  output logic           coef_re,
  output logic [CAW-1:0] coef_addr,
  output logic           samp_re,
  output logic [SAW-1:0] samp_raddr,
  output logic           samp_we,
  output logic [SAW-1:0] samp_waddr,
  output logic [DW-1:0]  samp_wdata,
  output logic           acc_clear,
  output logic           mac_fire,
  output logic           done,
  output logic           busy
);
  import fir_seq_pkg::*;

  // Named internal events, also watched by the checker.
  logic accept, fetch, first_fetch, last_fetch;
  logic [SAW-1:0] wr_slot, rd_slot, cf_slot, walk_origin;

  fir_tap_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .fetch(fetch), .first_fetch(first_fetch),
    .last_fetch(last_fetch), .fire(mac_fire), .done(done), .busy(busy)
  );

  assign walk_origin = SAW'(newest_slot(32'(wr_slot), TAPS, smp_valid));

  fir_ring_agu #(.LEN(TAPS), .AW(SAW), .DOWN(1'b0)) u_wr_agu (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
    .step(smp_valid), .ptr(wr_slot)
  );

  fir_ring_agu #(.LEN(TAPS), .AW(SAW), .DOWN(1'b1)) u_rd_agu (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(walk_origin),
    .step(fetch), .ptr(rd_slot)
  );

  fir_ring_agu #(.LEN(TAPS), .AW(SAW), .DOWN(1'b0)) u_cf_agu (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val('0),
    .step(fetch), .ptr(cf_slot)
  );

  assign coef_re    = fetch;
  assign coef_addr  = CAW'(COEF_BASE) + CAW'(cf_slot);
  assign samp_re    = fetch;
  assign samp_raddr = rd_slot;
  assign samp_we    = smp_valid;
  assign samp_waddr = wr_slot;
  assign samp_wdata = smp_data;
  assign acc_clear  = first_fetch;
endmodule

// File: rtl/fir_seq_chk.sv
module fir_seq_chk #(
  parameter int unsigned TAPS      = 8,
  parameter int unsigned CAW       = 6,
  parameter int unsigned SAW       = 3,
  parameter int unsigned COEF_BASE = 0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           accept,
  input logic           last_fetch,
  input logic           coef_re,
  input logic [CAW-1:0] coef_addr,
  input logic           samp_re,
  input logic [SAW-1:0] samp_raddr,
  input logic           samp_we,
  input logic [SAW-1:0] samp_waddr,
  input logic           acc_clear,
  input logic           mac_fire,
  input logic           done,
  input logic           busy
);
  localparam logic [SAW-1:0] TOP = SAW'(TAPS - 1);

  a_r2_clear_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> acc_clear && coef_re && samp_re);

  a_r2_clear_opens_run: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |-> !$past(coef_re));

  a_r3_coef_from_base: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |-> coef_addr == CAW'(COEF_BASE));

  a_r3_coef_climbs: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_re && !acc_clear) |-> coef_addr == CAW'($past(coef_addr) + 1'b1));

  a_r4_samp_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_re && !acc_clear) |->
      samp_raddr == (($past(samp_raddr) == '0) ? TOP : SAW'($past(samp_raddr) - 1'b1)));

  a_r5_fire_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    coef_re |=> mac_fire);

  a_r5_fire_has_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire |-> $past(coef_re));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_fetch |=> ##1 done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  a_r8_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    $past(samp_we) |->
      samp_waddr == (($past(samp_waddr) == TOP) ? '0 : SAW'($past(samp_waddr) + 1'b1)));

  a_r8_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(samp_we) |-> $stable(samp_waddr));
endmodule

bind fir_seq_ctrl fir_seq_chk #(
  .TAPS(TAPS), .CAW(CAW), .SAW(SAW), .COEF_BASE(COEF_BASE)
) u_fir_seq_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .last_fetch(last_fetch),
  .coef_re(coef_re), .coef_addr(coef_addr), .samp_re(samp_re),
  .samp_raddr(samp_raddr), .samp_we(samp_we), .samp_waddr(samp_waddr),
  .acc_clear(acc_clear), .mac_fire(mac_fire), .done(done), .busy(busy)
);

// File: tb/test_fir_seq_ctrl.sv
`timescale 1ns/100ps
module test_fir_seq_ctrl;
  localparam int N    = 5;
  localparam int DW   = 16;
  localparam int CAW  = 6;
  localparam int SAW  = 3;
  localparam int BASE = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic coef_re, samp_re, samp_we, acc_clear, mac_fire, done, busy;
  logic [CAW-1:0] coef_addr;
  logic [SAW-1:0] samp_raddr, samp_waddr;
  logic [DW-1:0] samp_wdata;

  int tests = 0, fails = 0;
  int wp = 0;
  logic [DW-1:0] hist[$];
  logic [DW-1:0] exp_c[$], exp_s[$];

  always #2.5 clk = ~clk;

  fir_seq_ctrl #(.TAPS(N), .DW(DW), .CAW(CAW), .COEF_BASE(BASE)) i_fir_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_re(coef_re), .coef_addr(coef_addr), .samp_re(samp_re), .samp_raddr(samp_raddr),
    .samp_we(samp_we), .samp_waddr(samp_waddr), .samp_wdata(samp_wdata),
    .acc_clear(acc_clear), .mac_fire(mac_fire), .done(done), .busy(busy)
  );

  // Memory models with one-cycle read latency.
  function automatic logic [DW-1:0] coef_val(int k);
    return DW'(k * 37 + 5);
  endfunction

  logic [DW-1:0] cmem[2**CAW];
  logic [DW-1:0] smem[N];
  logic [DW-1:0] cq, sq;
  initial begin
    for (int i = 0; i < 2**CAW; i++) cmem[i] = DW'(16'hdead);
    for (int k = 0; k < N; k++) cmem[BASE + k] = coef_val(k);
    for (int i = 0; i < N; i++) smem[i] = '0;
  end
  always @(posedge clk) begin
    if (samp_we) smem[samp_waddr] <= samp_wdata;
    if (samp_re) sq <= smem[samp_raddr];
    if (coef_re) cq <= cmem[coef_addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every fire cycle pops one expected operand pair.
  always @(negedge clk) begin
    if (rst_n && mac_fire) begin
      if (exp_c.size() == 0) chk(1'b0, "R5", "unexpected fire", 1, 0);
      else begin
        logic [DW-1:0] ec, es;
        ec = exp_c.pop_front();
        es = exp_s.pop_front();
        chk(cq == ec, "R5", "coefficient operand", int'(cq), int'(ec));
        chk(sq == es, "R5", "sample operand", int'(sq), int'(es));
      end
    end
  end

  task automatic push_sample(input logic [DW-1:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = v;
    #0.5;
    chk(samp_we == 1'b1, "R8", "write enable", int'(samp_we), 1);
    chk(int'(samp_waddr) == wp, "R8", "write slot", int'(samp_waddr), wp);
    chk(samp_wdata == v, "R8", "write data", int'(samp_wdata), int'(v));
    hist.push_back(v);
    wp = (wp + 1) % N;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // Driver: pushes the expected pairs, starts a run and checks the strobes.
  task automatic do_run(input bit with_smp, input logic [DW-1:0] sv, input bit poke);
    int newest;
    if (with_smp) begin
      newest = wp;
      hist.push_back(sv);
      wp = (wp + 1) % N;
    end else newest = (wp + N - 1) % N;
    for (int k = 0; k < N; k++) begin
      exp_c.push_back(coef_val(k));
      exp_s.push_back((k < hist.size()) ? hist[hist.size() - 1 - k] : '0);
    end
    @(negedge clk);
    start = 1'b1;
    if (with_smp) begin smp_valid = 1'b1; smp_data = sv; end
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (poke && k == 2) start = 1'b1;
      if (poke && k == 3) start = 1'b0;
      chk(coef_re && samp_re, "R2", "fetch strobes", int'(coef_re), 1);
      chk(acc_clear == (k == 0), "R2", "clear strobe", int'(acc_clear), int'(k == 0));
      chk(int'(coef_addr) == BASE + k, "R3", "coefficient address", int'(coef_addr), BASE + k);
      chk(int'(samp_raddr) == (newest - k + N) % N, "R4", "sample address",
          int'(samp_raddr), (newest - k + N) % N);
      chk(busy == 1'b1, "R6", "busy in run", int'(busy), 1);
      @(negedge clk);
    end
    chk(coef_re == 1'b0, "R2", "fetch ends after TAPS", int'(coef_re), 0);
    chk(done == 1'b0, "R6", "done early", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R6", "done at TAPS+2", int'(done), 1);
    chk(busy == 1'b0, "R6", "busy at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done single pulse", int'(done), 0);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        chk(coef_re == 1'b0 && busy == 1'b0, "R7", "no run from ignored start", int'(coef_re), 0);
        @(negedge clk);
      end
    end
    chk(exp_c.size() == 0, "R5", "all pairs consumed", exp_c.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mac_fire && !acc_clear && !coef_re && !samp_re, "R1",
        "idle outputs", int'(busy), 0);
    chk(samp_waddr == '0, "R1", "write slot after reset", int'(samp_waddr), 0);

    push_sample(16'd11); push_sample(16'd22); push_sample(16'd33);
    do_run(1'b0, '0, 1'b0);           // partial history, walk wraps 2,1,0,4,3
    push_sample(16'd44); push_sample(16'd55); push_sample(16'd66); push_sample(16'd77);
    do_run(1'b0, '0, 1'b0);           // write slot has wrapped
    do_run(1'b0, '0, 1'b0);           // R3: coefficient pointer back at base
    do_run(1'b1, 16'd88, 1'b0);       // R9: sample written with start
    do_run(1'b0, '0, 1'b1);           // R7: start during a run ignored
    push_sample(16'd99);
    do_run(1'b1, 16'd123, 1'b0);      // R9 again after a plain write
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule